// File: doc/BRIEF.md
# Processor Trace Status Encoder

This block sits beside a simple processor core and turns its per-cycle execution events into a 4-bit processor-status code stream and a 4-bit debug-data nibble stream, so that an external trace probe can rebuild program flow in real time. Each instruction start is tagged with a class. The class selects the start code, and it also sets whether a tail follows: a user-mode entry code, a data marker with serialised operand or target-address nibbles, or a run of emulator-entry codes.

The start code is always shown in the cycle after the event. Tails wait in a small record FIFO and are played out on cycles that carry no new instruction start. The stopped and halted states override everything else and freeze the queue until the core leaves them. When the FIFO is full, a stall request goes to the core.

Top module: `trace_status_encoder`

## Requirements
- R1: During and directly after reset, `pst` and `ddata` are 0 and `stall` is low.
- R2: An accepted `insn_start` drives, on the next cycle, `pst` = 0x1 for classes plain (0), status-register write (1) and capture (4), 0x7 for return-from-exception (2), and 0x5 for taken branch (3).
- R3: A cycle with no accepted start, no stop or halt, and no pending tail produces `pst` = 0x0 and `ddata` = 0 on the next cycle.
- R4: A status-register write or return-from-exception started with `enter_user` high is followed by one `pst` = 0x3 step before any other tail step. Without `enter_user`, no 0x3 appears.
- R5: A data tail shows the marker `pst` = 0x8 + `data_size` (`data_size` is byte count minus one). On the following tail steps, `data_val` goes out on `ddata`, least-significant nibble first, one nibble per step, 2×(`data_size`+1) nibbles, with `pst` = 0x0. In every other cycle `ddata` is 0.
- R6: A taken branch adds a data tail carrying the target address only when `show_target` is high. Otherwise it produces no tail.
- R7: A return-from-exception started with `enter_emu` high ends its tail with exactly EMU_CYCLES steps of `pst` = 0xD. Without `enter_emu` it produces none.
- R8: While `core_halted` is high, `pst` is 0xF on the next cycle, whatever `core_stopped` is. Otherwise, while `core_stopped` is high, it is 0xE. In both states the tail queue holds its position and resumes from the same step afterwards.
- R9: An accepted start takes the output slot ahead of a pending tail step. That step is shown in the next free cycle instead.
- R10: `stall` is high exactly while DEPTH tail records are pending. A tail-producing start that arrives while the queue is full has its tail discarded, but its start code is still shown.
- R11: `insn_start` is ignored while `core_stopped` or `core_halted` is high: no start code is shown and no tail is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_start | input | 1 | An instruction begins execution this cycle |
| insn_class | input | 3 | Instruction class: 0 plain, 1 status write, 2 return-from-exception, 3 taken branch, 4 capture |
| enter_user | input | 1 | The instruction drops the core into user mode |
| enter_emu | input | 1 | The return-from-exception lands in emulator mode |
| show_target | input | 1 | The branch target address is to be traced |
| data_size | input | 2 | Captured byte count minus one |
| data_val | input | 32 | Operand or target address to capture |
| core_stopped | input | 1 | Core is in the stopped state |
| core_halted | input | 1 | Core is in the halted state |
| pst | output | 4 | Processor-status code |
| ddata | output | 4 | Debug-data nibble |
| stall | output | 1 | Stall request to the core: tail queue full |

## Verification
A wrong step counter shows up as a marker value or a nibble count that is off, and it appears at `ddata` within one to eight cycles of the marker. A corrupted phase shows up as a missing or misplaced 0x3 or 0xD code in the cycle right after the start code, or right after the last nibble. A FIFO pointer or count error shows up in two ways: `stall` rises or falls one record early or late, or a discarded tail reappears as an extra marker once the queue drains. Frozen-state faults show up when the first step after leaving stop or halt is not the one that was pending.

// File: rtl/trace_pkg.sv
package trace_pkg;

    localparam int DATA_W = 32;
    localparam int SIZE_W = $clog2(DATA_W / 8);

    typedef enum logic [2:0] {
        IC_PLAIN   = 3'd0,
        IC_SRWRITE = 3'd1,
        IC_RTE     = 3'd2,
        IC_BRANCH  = 3'd3,
        IC_CAPTURE = 3'd4
    } iclass_e;

    localparam logic [3:0] CODE_IDLE   = 4'h0;
    localparam logic [3:0] CODE_BEGIN  = 4'h1;
    localparam logic [3:0] CODE_USER   = 4'h3;
    localparam logic [3:0] CODE_FLOW   = 4'h5;
    localparam logic [3:0] CODE_RETURN = 4'h7;
    localparam logic [3:0] CODE_MARK0  = 4'h8;
    localparam logic [3:0] CODE_EMU    = 4'hD;
    localparam logic [3:0] CODE_STOP   = 4'hE;
    localparam logic [3:0] CODE_HALT   = 4'hF;

    typedef enum logic [1:0] {
        PH_USER = 2'd0,
        PH_MARK = 2'd1,
        PH_NIB  = 2'd2,
        PH_EMU  = 2'd3
    } phase_e;

    typedef struct packed {
        logic              user;
        logic              emu;
        logic              has_data;
        logic [SIZE_W-1:0] size;
        logic [DATA_W-1:0] data;
    } tail_t;

    localparam int TAIL_W = $bits(tail_t);

    function automatic logic [3:0] start_code(iclass_e c);
        case (c)
            IC_RTE:    return CODE_RETURN;
            IC_BRANCH: return CODE_FLOW;
            default:   return CODE_BEGIN;
        endcase
    endfunction

    function automatic logic needs_tail(tail_t t);
        return t.user | t.emu | t.has_data;
    endfunction

    function automatic phase_e first_phase(tail_t t);
        if (t.user)
            return PH_USER;
        else if (t.has_data)
            return PH_MARK;
        else
            return PH_EMU;
    endfunction

    function automatic logic [3:0] marker_code(logic [SIZE_W-1:0] sz);
        return CODE_MARK0 + 4'(sz);
    endfunction

endpackage

// File: rtl/trace_fifo.sv
module trace_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign count   = cnt_q;
    assign dout    = mem[rd_ptr];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= bump(wr_ptr);
            if (do_pop)
                rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/trace_sequencer.sv
module trace_sequencer
    import trace_pkg::*;
#(
    parameter int EMU_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    input  logic       head_valid,
    input  tail_t      head,
    output logic [3:0] step_pst,
    output logic [3:0] step_dd,
    output logic       pop
);
    localparam int MAX_NIB = 2 * (DATA_W / 8);
    localparam int LIM     = (EMU_CYCLES > MAX_NIB) ? EMU_CYCLES : MAX_NIB;
    localparam int CNT_W   = $clog2(LIM + 1);

    phase_e           ph_q, eff_ph, nxt_ph;
    logic             fresh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done;
    logic [DATA_W-1:0] shifted;
    logic [CNT_W-1:0] nib_last;

    assign eff_ph   = fresh_q ? first_phase(head) : ph_q;
    assign shifted  = head.data >> {cnt_q, 2'b00};
    assign nib_last = CNT_W'({head.size, 1'b1});

    always_comb begin
        step_pst = CODE_IDLE;
        step_dd  = 4'h0;
        nxt_ph   = eff_ph;
        done     = 1'b0;
        case (eff_ph)
            PH_USER: begin
                step_pst = CODE_USER;
                if (head.has_data)
                    nxt_ph = PH_MARK;
                else if (head.emu)
                    nxt_ph = PH_EMU;
                else
                    done = 1'b1;
            end
            PH_MARK: begin
                step_pst = marker_code(head.size);
                nxt_ph   = PH_NIB;
            end
            PH_NIB: begin
                step_dd = shifted[3:0];
                if (cnt_q == nib_last) begin
                    if (head.emu)
                        nxt_ph = PH_EMU;
                    else
                        done = 1'b1;
                end
            end
            default: begin
                step_pst = CODE_EMU;
                if (cnt_q == CNT_W'(EMU_CYCLES - 1))
                    done = 1'b1;
            end
        endcase
    end

    assign pop = advance && head_valid && done;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_USER;
            fresh_q <= 1'b1;
            cnt_q   <= '0;
        end else if (advance && head_valid) begin
            if (done) begin
                fresh_q <= 1'b1;
                cnt_q   <= '0;
            end else begin
                fresh_q <= 1'b0;
                ph_q    <= nxt_ph;
                cnt_q   <= (nxt_ph == eff_ph) ? cnt_q + 1'b1 : '0;
            end
        end
    end

endmodule

// File: rtl/trace_status_encoder.sv
module trace_status_encoder
    import trace_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int EMU_CYCLES = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   insn_start,
    input  logic [2:0]             insn_class,
    input  logic                   enter_user,
    input  logic                   enter_emu,
    input  logic                   show_target,
    input  logic [SIZE_W-1:0]      data_size,
    input  logic [DATA_W-1:0]      data_val,
    input  logic                   core_stopped,
    input  logic                   core_halted,
    output logic [3:0]             pst,
    output logic [3:0]             ddata,
    output logic                   stall
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    iclass_e          cls;
    tail_t            new_rec, head;
    logic [TAIL_W-1:0] head_bits;
    logic             blocked, accept, push, advance, pop;
    logic             q_empty, q_full;
    logic [CNT_W-1:0] q_count;
    logic [3:0]       step_pst, step_dd;
    logic [3:0]       pst_n, dd_n;

    assign cls     = iclass_e'(insn_class);
    assign blocked = core_stopped | core_halted;
    assign accept  = insn_start && !blocked;
    assign advance = !blocked && !insn_start;

    always_comb begin
        new_rec.user     = enter_user && (cls == IC_SRWRITE || cls == IC_RTE);
        new_rec.emu      = enter_emu && (cls == IC_RTE);
        new_rec.has_data = (cls == IC_CAPTURE) || (cls == IC_BRANCH && show_target);
        new_rec.size     = data_size;
        new_rec.data     = data_val;
    end

    assign push = accept && needs_tail(new_rec);
    assign head = tail_t'(head_bits);

    trace_fifo #(
        .W     (TAIL_W),
        .DEPTH (DEPTH)
    ) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (new_rec),
        .pop   (pop),
        .dout  (head_bits),
        .empty (q_empty),
        .full  (q_full),
        .count (q_count)
    );

    trace_sequencer #(
        .EMU_CYCLES (EMU_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .advance    (advance),
        .head_valid (!q_empty),
        .head       (head),
        .step_pst   (step_pst),
        .step_dd    (step_dd),
        .pop        (pop)
    );

    always_comb begin
        dd_n = 4'h0;
        if (core_halted)
            pst_n = CODE_HALT;
        else if (core_stopped)
            pst_n = CODE_STOP;
        else if (insn_start)
            pst_n = start_code(cls);
        else if (!q_empty) begin
            pst_n = step_pst;
            dd_n  = step_dd;
        end else
            pst_n = CODE_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pst   <= CODE_IDLE;
            ddata <= 4'h0;
        end else begin
            pst   <= pst_n;
            ddata <= dd_n;
        end
    end

    assign stall = q_full;

    logic unused_cnt;
    assign unused_cnt = ^q_count;

endmodule

// File: rtl/trace_status_encoder_chk.sv
module trace_status_encoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       insn_start,
    input logic [2:0] insn_class,
    input logic       core_stopped,
    input logic       core_halted,
    input logic [3:0] pst,
    input logic [3:0] ddata
);
    AST_HALT_CODE: assert property (@(posedge clk) disable iff (rst)
        core_halted |=> pst == 4'hF);                                      // R8
    AST_STOP_CODE: assert property (@(posedge clk) disable iff (rst)
        core_stopped && !core_halted |=> pst == 4'hE);                      // R8
    AST_RETURN_START: assert property (@(posedge clk) disable iff (rst)
        insn_start && !core_stopped && !core_halted && insn_class == 3'd2
        |=> pst == 4'h7);                                                  // R2
    AST_BRANCH_START: assert property (@(posedge clk) disable iff (rst)
        insn_start && !core_stopped && !core_halted && insn_class == 3'd3
        |=> pst == 4'h5);                                                  // R2
    AST_DDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        pst != 4'h0 |-> ddata == 4'h0);                                    // R5
endmodule

bind trace_status_encoder trace_status_encoder_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .insn_start   (insn_start),
    .insn_class   (insn_class),
    .core_stopped (core_stopped),
    .core_halted  (core_halted),
    .pst          (pst),
    .ddata        (ddata)
);

// File: tb/trace_status_encoder_bench.sv
module trace_status_encoder_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        insn_start, enter_user, enter_emu, show_target;
    logic [2:0]  insn_class;
    logic [1:0]  data_size;
    logic [31:0] data_val;
    logic        core_stopped, core_halted;
    logic [3:0]  pst, ddata;
    logic        stall;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    trace_status_encoder u_trace_status_encoder (
        .clk          (clk),
        .rst          (rst),
        .insn_start   (insn_start),
        .insn_class   (insn_class),
        .enter_user   (enter_user),
        .enter_emu    (enter_emu),
        .show_target  (show_target),
        .data_size    (data_size),
        .data_val     (data_val),
        .core_stopped (core_stopped),
        .core_halted  (core_halted),
        .pst          (pst),
        .ddata        (ddata),
        .stall        (stall)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        st;
        logic [2:0]  cls;
        logic        usr;
        logic        emu;
        logic        shw;
        logic [1:0]  sz;
        logic [31:0] dat;
        logic        stp;
        logic        hlt;
        logic [3:0]  ep;
        logic [3:0]  ed;
        logic        es;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VEC [NV] = '{
        '{4'd3, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'h0,1'b0},
        '{4'd2, 1'b1,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h1,4'h0,1'b0},
        '{4'd3, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'h0,1'b0},
        '{4'd6, 1'b1,3'd3,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h5,4'h0,1'b0},
        '{4'd6, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'h0,1'b0},
        '{4'd2, 1'b1,3'd4,1'b0,1'b0,1'b0,2'd1,32'hA5C3,  1'b0,1'b0,4'h1,4'h0,1'b0},
        '{4'd5, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h9,4'h0,1'b0},
        '{4'd5, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'h3,1'b0},
        '{4'd5, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'hC,1'b0},
        '{4'd5, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'h5,1'b0},
        '{4'd5, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'hA,1'b0},
        '{4'd3, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'h0,1'b0},
        '{4'd4, 1'b1,3'd1,1'b1,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h1,4'h0,1'b0},
        '{4'd4, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h3,4'h0,1'b0},
        '{4'd4, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'h0,1'b0},
        '{4'd2, 1'b1,3'd2,1'b1,1'b1,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h7,4'h0,1'b0},
        '{4'd4, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h3,4'h0,1'b0},
        '{4'd7, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'hD,4'h0,1'b0},
        '{4'd7, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'hD,4'h0,1'b0},
        '{4'd7, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'hD,4'h0,1'b0},
        '{4'd7, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'h0,1'b0},
        '{4'd6, 1'b1,3'd3,1'b0,1'b0,1'b1,2'd0,32'h5E,    1'b0,1'b0,4'h5,4'h0,1'b0},
        '{4'd9, 1'b1,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h1,4'h0,1'b0},
        '{4'd6, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h8,4'h0,1'b0},
        '{4'd6, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'hE,1'b0},
        '{4'd6, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'h5,1'b0},
        '{4'd3, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'h0,1'b0},
        '{4'd2, 1'b1,3'd4,1'b0,1'b0,1'b0,2'd0,32'h7B,    1'b0,1'b0,4'h1,4'h0,1'b0},
        '{4'd8, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b1,1'b0,4'hE,4'h0,1'b0},
        '{4'd8, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b1,1'b1,4'hF,4'h0,1'b0},
        '{4'd8, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h8,4'h0,1'b0},
        '{4'd11,1'b1,3'd4,1'b0,1'b0,1'b0,2'd0,32'h11,    1'b1,1'b0,4'hE,4'h0,1'b0},
        '{4'd5, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'hB,1'b0},
        '{4'd5, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'h7,1'b0},
        '{4'd11,1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'h0,1'b0},
        '{4'd2, 1'b1,3'd2,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h7,4'h0,1'b0},
        '{4'd4, 1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0,     1'b0,1'b0,4'h0,4'h0,1'b0}
    };

    function automatic string rname(logic [3:0] id);
        case (id)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string req, string what, logic [8:0] act, logic [8:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic quiet();
        insn_start = 1'b0; insn_class = 3'd0; enter_user = 1'b0; enter_emu = 1'b0;
        show_target = 1'b0; data_size = 2'd0; data_val = 32'h0;
        core_stopped = 1'b0; core_halted = 1'b0;
    endtask

    task automatic capture(logic [1:0] sz, logic [31:0] d);
        quiet();
        insn_start = 1'b1; insn_class = 3'd4; data_size = sz; data_val = d;
    endtask

    // checks {pst, ddata, stall} after the next edge
    task automatic step_check(string req, string what, logic [3:0] ep, logic [3:0] ed, logic es);
        @(negedge clk);
        check(req, what, {pst, ddata, stall}, {ep, ed, es});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (R1)");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        quiet();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "reset outputs", {pst, ddata, stall}, 9'h0);
        rst = 1'b0;
        step_check("R1", "first cycle after reset", 4'h0, 4'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            insn_start   = VEC[i].st;
            insn_class   = VEC[i].cls;
            enter_user   = VEC[i].usr;
            enter_emu    = VEC[i].emu;
            show_target  = VEC[i].shw;
            data_size    = VEC[i].sz;
            data_val     = VEC[i].dat;
            core_stopped = VEC[i].stp;
            core_halted  = VEC[i].hlt;
            @(negedge clk);
            check(rname(VEC[i].req), $sformatf("vector %0d", i),
                  {pst, ddata, stall}, {VEC[i].ep, VEC[i].ed, VEC[i].es});
        end

        // R5: four-byte capture, marker 0xB then eight nibbles LSB first
        capture(2'd3, 32'h1234_5678);
        step_check("R5", "4-byte start", 4'h1, 4'h0, 1'b0);
        quiet();
        step_check("R5", "4-byte marker", 4'hB, 4'h0, 1'b0);
        for (int k = 0; k < 8; k++)
            step_check("R5", $sformatf("nibble %0d", k), 4'h0, 4'(8 - k), 1'b0);
        step_check("R3", "after 4-byte tail", 4'h0, 4'h0, 1'b0);

        // R10: fill the queue with back-to-back captures
        capture(2'd0, 32'h12);
        step_check("R10", "fill 1", 4'h1, 4'h0, 1'b0);
        capture(2'd0, 32'h34);
        step_check("R10", "fill 2", 4'h1, 4'h0, 1'b0);
        capture(2'd0, 32'h56);
        step_check("R10", "fill 3", 4'h1, 4'h0, 1'b0);
        capture(2'd0, 32'h78);
        step_check("R10", "fill 4 raises stall", 4'h1, 4'h0, 1'b1);
        capture(2'd0, 32'hFF);
        step_check("R10", "start code while full", 4'h1, 4'h0, 1'b1);
        quiet();
        step_check("R10", "drain marker 1", 4'h8, 4'h0, 1'b1);
        step_check("R10", "drain nib 1a", 4'h0, 4'h2, 1'b1);
        step_check("R10", "drain nib 1b, stall drops", 4'h0, 4'h1, 1'b0);
        for (int r = 1; r < 4; r++) begin
            step_check("R10", "drain marker", 4'h8, 4'h0, 1'b0);
            step_check("R10", "drain nib lo", 4'h0, 4'(2 * r + 2), 1'b0);
            step_check("R10", "drain nib hi", 4'h0, 4'(2 * r + 1), 1'b0);
        end
        step_check("R10", "discarded tail absent", 4'h0, 4'h0, 1'b0);

        // R7: emulator entry without user entry goes straight to 0xD
        quiet();
        insn_start = 1'b1; insn_class = 3'd2; enter_emu = 1'b1;
        step_check("R7", "return start", 4'h7, 4'h0, 1'b0);
        quiet();
        for (int k = 0; k < 3; k++)
            step_check("R7", "emu code", 4'hD, 4'h0, 1'b0);
        step_check("R7", "emu run ends", 4'h0, 4'h0, 1'b0);

        // R1: reset in the middle of a pending tail clears everything
        capture(2'd3, 32'hCAFE_F00D);
        @(negedge clk);
        quiet();
        rst = 1'b1;
        @(negedge clk);
        check("R1", "mid-run reset", {pst, ddata, stall}, 9'h0);
        rst = 1'b0;
        step_check("R1", "queue cleared by reset", 4'h0, 4'h0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule